// File: doc/BRIEF.md
# E1 Automatic Alarm Generator

This block sits between the receive-side health detectors of an E1 line interface and the transmit formatter. It watches three receive conditions: frame alignment lost, an all-ones alarm signal arriving, and line carrier lost. When any of them is present, it asks the transmitter to send an alarm to the far end. Two mode-enable bits choose which alarm is sent. In one mode the transmitter is told to replace its line data with all ones. In the other mode the transmitter is told to set the remote-alarm indication. With both bits clear, no alarm is ever requested. With both bits set, the configuration is illegal: the block raises a flag and requests neither alarm.

In remote-alarm mode the block also times the search for CRC4 multiframe alignment. It counts 1 ms timebase ticks while CRC4 is enabled and multiframe sync is absent. Once the count reaches the timeout (400 ticks by default), it forces a constant remote alarm. That alarm holds until multiframe sync is found or CRC4 is turned off, whatever the three receive conditions are doing. All inputs are sampled on the system clock, and every output is a register.

Top module: `e1_auto_alarm_gen`

## Requirements
- R1: While both mode-enable bits (`mode_ais_en`, `mode_rai_en`) are 0, `force_ais` and `force_rai` are 0 on the clock that follows.
- R2: The receive trigger is the OR of `rx_lof`, `rx_ais` and `rx_los`. Any single one of them, or any mix of them, triggers alarm forcing. None of them triggers nothing.
- R3: With `mode_ais_en`=1, `mode_rai_en`=0 and the trigger present, `force_ais` is 1 one clock later and `force_rai` is 0. With the trigger absent, `force_ais` is 0 one clock later.
- R4: With `mode_rai_en`=1, `mode_ais_en`=0 and the trigger present, `force_rai` is 1 one clock later and `force_ais` is 0.
- R5: With both mode bits at 1, `cfg_illegal` is 1 one clock later, and `force_ais` and `force_rai` are both 0. In any other mode setting, `cfg_illegal` is 0 one clock later.
- R6: A search timer advances by one on each clock where `tick_1ms`=1 while `crc4_en`=1 and `crc4_mf_sync`=0. Once it holds TIMEOUT_TICKS, and that search condition still holds, remote-alarm mode (R4 settings) forces `force_rai`=1 one clock later with no trigger present. In AIS mode the timeout leaves `force_ais` and `force_rai` untouched.
- R7: The timer returns to zero on any clock with `crc4_mf_sync`=1 or `crc4_en`=0. A timeout-driven `force_rai` falls one clock after such an input, and it takes a fresh run of TIMEOUT_TICKS ticks to force it again.
- R8: The timer saturates at TIMEOUT_TICKS instead of wrapping. Any number of further ticks keeps the timeout-driven `force_rai` at 1.
- R9: A synchronous active-high `rst` clears the timer and drives all three outputs to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ais_en | input | 1 | Mode bit: on a trigger, send all ones |
| mode_rai_en | input | 1 | Mode bit: on a trigger or search timeout, send remote alarm |
| rx_lof | input | 1 | Receive frame alignment lost |
| rx_ais | input | 1 | All-ones alarm detected on receive |
| rx_los | input | 1 | Receive carrier lost |
| crc4_en | input | 1 | CRC4 multiframing enabled |
| crc4_mf_sync | input | 1 | CRC4 multiframe alignment found |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| force_ais | output | 1 | Request to replace transmit data with all ones |
| force_rai | output | 1 | Request to set the transmit remote-alarm bit |
| cfg_illegal | output | 1 | Both mode bits are set |

## Verification
The bench builds the block with TIMEOUT_TICKS set to 6. At that value the search timeout, its saturation and its clearing can all be reached in a few tens of cycles instead of 400 ticks. With a timeout this short, one run can cover several things. It sweeps every combination of the two mode bits, the three receive conditions, the CRC4 enable and multiframe sync. It runs long pseudo-random sequences with dense ticks that cross the timeout edge many times. It also checks a reset issued while the timer sits one tick short of expiry. Each output is compared against an arithmetic model of the timer and the mode decision on every cycle.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_AIS = 2'b01,
    MODE_RAI = 2'b10,
    MODE_BAD = 2'b11
  } alarm_mode_e;

  typedef struct packed {
    logic lof;
    logic ais;
    logic los;
  } rx_health_t;

  // Mode selection from the two enable bits.
  function automatic alarm_mode_e mode_of(input logic ais_bit, input logic rai_bit);
    return alarm_mode_e'({rai_bit, ais_bit});
  endfunction

  // Any receive defect triggers alarm forcing.
  function automatic logic rx_fault(input rx_health_t h);
    return h.lof | h.ais | h.los;
  endfunction

  // The search timer runs only while CRC4 is on and multiframe sync is missing.
  function automatic logic search_active(input logic en, input logic sync);
    return en & ~sync;
  endfunction

endpackage

// File: rtl/e1_alarm_mode_dec.sv
module e1_alarm_mode_dec
  import e1_alarm_pkg::*;
(
  input  logic        ais_bit,
  input  logic        rai_bit,
  input  logic        lof,
  input  logic        ais_seen,
  input  logic        los,
  output alarm_mode_e mode,
  output logic        trigger
);

  rx_health_t health;

  always_comb begin
    health.lof = lof;
    health.ais = ais_seen;
    health.los = los;
    mode       = mode_of(ais_bit, rai_bit);
    trigger    = rx_fault(health);
  end

endmodule

// File: rtl/e1_crc4_search_timer.sv
module e1_crc4_search_timer
  import e1_alarm_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 400,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc4_en,
  input  logic             mf_sync,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             timeout_hit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

  logic searching;
  logic at_limit;

  always_comb begin
    searching   = search_active(crc4_en, mf_sync);
    at_limit    = (count == LIMIT);
    timeout_hit = searching & at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst || !searching) begin
      count <= '0;
    end else if (tick && !at_limit) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/e1_alarm_out_reg.sv
module e1_alarm_out_reg
  import e1_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  alarm_mode_e mode,
  input  logic        trigger,
  input  logic        timeout_hit,
  output logic        force_ais,
  output logic        force_rai,
  output logic        cfg_illegal
);

  logic ais_next;
  logic rai_next;
  logic bad_next;

  always_comb begin
    ais_next = (mode == MODE_AIS) & trigger;
    rai_next = (mode == MODE_RAI) & (trigger | timeout_hit);
    bad_next = (mode == MODE_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_ais   <= 1'b0;
      force_rai   <= 1'b0;
      cfg_illegal <= 1'b0;
    end else begin
      force_ais   <= ais_next;
      force_rai   <= rai_next;
      cfg_illegal <= bad_next;
    end
  end

endmodule

// File: rtl/e1_auto_alarm_gen.sv
module e1_auto_alarm_gen
  import e1_alarm_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_ais_en,
  input  logic mode_rai_en,
  input  logic rx_lof,
  input  logic rx_ais,
  input  logic rx_los,
  input  logic crc4_en,
  input  logic crc4_mf_sync,
  input  logic tick_1ms,
  output logic force_ais,
  output logic force_rai,
  output logic cfg_illegal
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  alarm_mode_e      mode;
  logic             trigger;
  logic [CNT_W-1:0] timer_cnt;
  logic             timeout_hit;

  e1_alarm_mode_dec dec_i (
    .ais_bit  (mode_ais_en),
    .rai_bit  (mode_rai_en),
    .lof      (rx_lof),
    .ais_seen (rx_ais),
    .los      (rx_los),
    .mode     (mode),
    .trigger  (trigger)
  );

  e1_crc4_search_timer #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) tmr_i (
    .clk         (clk),
    .rst         (rst),
    .crc4_en     (crc4_en),
    .mf_sync     (crc4_mf_sync),
    .tick        (tick_1ms),
    .count       (timer_cnt),
    .timeout_hit (timeout_hit)
  );

  e1_alarm_out_reg out_i (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .trigger     (trigger),
    .timeout_hit (timeout_hit),
    .force_ais   (force_ais),
    .force_rai   (force_rai),
    .cfg_illegal (cfg_illegal)
  );

endmodule

// File: rtl/e1_auto_alarm_gen_chk.sv
module e1_auto_alarm_gen_chk #(
  parameter int TIMEOUT_TICKS = 400,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_ais_en,
  input logic             mode_rai_en,
  input logic             rx_lof,
  input logic             rx_ais,
  input logic             rx_los,
  input logic             crc4_en,
  input logic             crc4_mf_sync,
  input logic             tick_1ms,
  input logic             force_ais,
  input logic             force_rai,
  input logic             cfg_illegal,
  input logic [CNT_W-1:0] timer_cnt,
  input logic             timeout_hit
);

  logic any_rx;
  logic rai_only;
  logic [CNT_W-1:0] ref_ticks;

  assign any_rx   = rx_lof | rx_ais | rx_los;
  assign rai_only = mode_rai_en & ~mode_ais_en;

  // Independent tick tally for the timeout window.
  always_ff @(posedge clk) begin
    if (rst || !crc4_en || crc4_mf_sync) ref_ticks <= '0;
    else if (tick_1ms && ref_ticks != CNT_W'(TIMEOUT_TICKS)) ref_ticks <= ref_ticks + 1'b1;
  end

  assert_modes_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!mode_ais_en && !mode_rai_en) |=> (!force_ais && !force_rai));

  assert_any_cond_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_ais_en && !mode_rai_en && any_rx) |=> force_ais);

  assert_ais_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_ais_en && !mode_rai_en) |=> !force_rai);

  assert_rai_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (rai_only && any_rx) |=> (force_rai && !force_ais));

  assert_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_ais_en && mode_rai_en) |=> (cfg_illegal && !force_ais && !force_rai));

  assert_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    (rai_only && crc4_en && !crc4_mf_sync && ref_ticks == CNT_W'(TIMEOUT_TICKS)) |=> force_rai);

  assert_sync_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (!crc4_en || crc4_mf_sync) |-> !timeout_hit);

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    timer_cnt <= CNT_W'(TIMEOUT_TICKS));

  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!force_ais && !force_rai && !cfg_illegal && timer_cnt == '0));

endmodule

bind e1_auto_alarm_gen e1_auto_alarm_gen_chk #(
  .TIMEOUT_TICKS (TIMEOUT_TICKS)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mode_ais_en  (mode_ais_en),
  .mode_rai_en  (mode_rai_en),
  .rx_lof       (rx_lof),
  .rx_ais       (rx_ais),
  .rx_los       (rx_los),
  .crc4_en      (crc4_en),
  .crc4_mf_sync (crc4_mf_sync),
  .tick_1ms     (tick_1ms),
  .force_ais    (force_ais),
  .force_rai    (force_rai),
  .cfg_illegal  (cfg_illegal),
  .timer_cnt    (timer_cnt),
  .timeout_hit  (timeout_hit)
);

// File: tb/e1_auto_alarm_gen_tb.sv
module e1_auto_alarm_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_TICKS    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_ais_en = 0, mode_rai_en = 0;
  logic rx_lof = 0, rx_ais = 0, rx_los = 0;
  logic crc4_en = 0, crc4_mf_sync = 0, tick_1ms = 0;
  logic force_ais, force_rai, cfg_illegal;

  int vectors = 0;
  int fails   = 0;
  int mcnt    = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_auto_alarm_gen #(.TIMEOUT_TICKS(T_TICKS)) dut_i (
    .clk(clk), .rst(rst),
    .mode_ais_en(mode_ais_en), .mode_rai_en(mode_rai_en),
    .rx_lof(rx_lof), .rx_ais(rx_ais), .rx_los(rx_los),
    .crc4_en(crc4_en), .crc4_mf_sync(crc4_mf_sync), .tick_1ms(tick_1ms),
    .force_ais(force_ais), .force_rai(force_rai), .cfg_illegal(cfg_illegal)
  );

  task automatic cmp(input string tag, input string name, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Called at a negedge with inputs set; predicts the outputs after the next posedge.
  task automatic step(input string tag);
    logic trig, srch, hit, e_ais, e_rai, e_bad;
    trig  = rx_lof | rx_ais | rx_los;
    srch  = crc4_en & ~crc4_mf_sync;
    hit   = srch && (mcnt == T_TICKS);
    e_ais = !rst && mode_ais_en && !mode_rai_en && trig;
    e_rai = !rst && mode_rai_en && !mode_ais_en && (trig || hit);
    e_bad = !rst && mode_ais_en && mode_rai_en;
    if (rst || !srch) mcnt = 0;
    else if (tick_1ms && mcnt < T_TICKS) mcnt = mcnt + 1;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    cmp(tag, "force_ais", force_ais, e_ais);
    cmp(tag, "force_rai", force_rai, e_rai);
    cmp(tag, "cfg_illegal", cfg_illegal, e_bad);
  endtask

  function automatic string auto_tag();
    if (mode_ais_en && mode_rai_en) return "R5";
    if (!mode_ais_en && !mode_rai_en) return "R1";
    if (mode_ais_en) return "R3";
    if (rx_lof | rx_ais | rx_los) return "R4";
    return "R6";
  endfunction

  task automatic set_in(input logic [7:0] v);
    {mode_rai_en, mode_ais_en, rx_lof, rx_ais, rx_los, crc4_en, crc4_mf_sync, tick_1ms} = v;
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    rst = 1;
    step("R9");
    step("R9");
    rst = 0;

    // Exhaustive sweep of modes, conditions and CRC4 state, no ticks (R1..R5, R2).
    for (int v = 0; v < 128; v++) begin
      set_in({v[6:0], 1'b0});
      step(v[6:5] == 2'b01 ? "R2" : auto_tag());
    end

    // Timeout in remote-alarm mode with dense ticks, then saturation.
    set_in(8'b1000_0100); // rai mode, crc4 on, no sync, no ticks
    step("R7");
    tick_1ms = 1;
    for (int i = 0; i < T_TICKS + 8; i++) step(i < T_TICKS ? "R6" : "R8");
    // Sync found: timeout alarm drops.
    tick_1ms = 0; crc4_mf_sync = 1; step("R7");
    crc4_mf_sync = 0; step("R7");
    // Sparse ticks: a fresh full run is needed.
    for (int i = 0; i < 3 * (T_TICKS + 3); i++) begin
      tick_1ms = (i % 3 == 0);
      step("R6");
    end
    tick_1ms = 0; crc4_en = 0; step("R7");
    crc4_en = 1; step("R7");

    // Timeout reached under AIS mode has no effect.
    set_in(8'b0100_0101);
    for (int i = 0; i < T_TICKS + 3; i++) step("R6");
    mode_ais_en = 0; mode_rai_en = 1; tick_1ms = 0;
    step("R6");

    // Reset one tick short of timeout.
    set_in(8'b1000_0101);
    for (int i = 0; i < T_TICKS - 1; i++) step("R6");
    rst = 1; step("R9");
    rst = 0; step("R9");
    for (int i = 0; i < T_TICKS + 1; i++) step("R9");

    // Pseudo-random sequences with biased inputs.
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mode_ais_en  = (lfsr[2:0] == 3'd0);
      mode_rai_en  = (lfsr[2:0] != 3'd1);
      rx_lof       = (lfsr[6:3] == 4'd0);
      rx_ais       = (lfsr[9:7] == 3'd0);
      rx_los       = (lfsr[12:10] == 3'd0);
      crc4_en      = (lfsr[13] | lfsr[14]);
      crc4_mf_sync = (lfsr[15:13] == 3'b111);
      tick_1ms     = lfsr[4] | lfsr[8];
      rst          = (lfsr == 16'h0F0F);
      step(rst ? "R9" : auto_tag());
    end
    rst = 0;

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule